// File: doc/BRIEF.md
# SPI Configuration-Load Sequencer

This block loads a configuration image into a target FPGA through its slave SPI port. On a start request it enables the target's configuration interface and reads back a one-byte enable result. It then switches the target into programming mode and sends the image in 16-byte frames. Each frame goes out as a single chip-select burst behind a frame opcode. Last, it leaves configuration, waits a settling time of at least one millisecond, and releases the target.

Before every command it reads the target's status byte until the busy bit is clear. Before the enable read-back it also waits for the ready bit. Image bytes come from a valid/ready byte stream, and the total byte count is given with the start request. A fault flag in the status, or too many polls without success, stops the run. The error code then records the step in which the failing poll occurred.

Top module: `spi_prog_seq`

## Requirements
- R1: No command opcode is clocked out until the most recent status reading showed bit 0 (busy) clear.
- R2: A status reading is two back-to-back one-byte chip-select bursts of opcode 0x00, and only the byte returned in the second burst is judged. Bit 0 is busy, bit 1 is ready, and bits 2 and 3 are faults.
- R3: The run opens with a one-byte burst 0x0B. It then polls until ready is set and busy is clear, and sends a burst 0x01 followed by one dummy byte. A nonzero byte returned during the dummy byte ends the run with error code 3.
- R4: The run then sends the two-byte burst 0xAE 0x01, and `prog_mode` goes high after it.
- R5: For a byte count of N, exactly N/16 frame bursts are sent. Each burst is 0xEE followed by 16 stream bytes in arrival order, and `in_ready` is only high while a frame's data bytes are being sent.
- R6: A byte count of zero, or one whose low four bits are not all zero, is refused with error code 2 one cycle after start, and the SPI pins stay idle.
- R7: A start with `partial` high is refused with error code 1 one cycle after start, and the SPI pins stay idle.
- R8: After the frames the block sends burst 0x0C, waits at least CLK_HZ/1000 cycles, and sends burst 0x23 no later than twice that wait. `prog_mode` then falls, and `done` pulses with error code 0.
- R9: A status fault bit, or MAX_POLLS readings without success, ends the run with error code 8 plus the step number. The step numbers are enable 0, enable read-back 1, mode entry 2, frame 3, disable 4 and release 5. `prog_mode` keeps its value after such a failure.
- R10: SPI runs in mode 0, MSB first. `spi_sclk` is low whenever `spi_cs_n` is high, and both are at their idle levels after reset.
- R11: `busy` is high from the cycle after an accepted start until `done`, which is a one-cycle pulse. A start while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a load run |
| partial | input | 1 | Request is a partial reconfiguration (refused) |
| byte_count | input | COUNT_W | Image length in bytes |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte available |
| in_ready | output | 1 | Image byte taken this cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_code | output | 4 | Result of the last run, held until the next start |
| prog_mode | output | 1 | Target is in programming mode |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to target |
| spi_miso | input | 1 | SPI data from target |

## Verification
Refusals are due on `done` and `err_code` one cycle after the start edge. The bench samples them at the first falling clock edge after that start edge and flags a refusal that arrives later. A full run ends on the `done` pulse, whose timing depends on the target's busy replies, so the bench waits for that pulse at falling edges and then reads the error code, `prog_mode` and the target-model log. A behavioural target records every burst, the cycle on which it ended, and the busy state of the last status byte it returned. That lets the poll gating, the frame layout and the settling gap be checked at the pins without cycle-exact prediction.

// File: rtl/spi_prog_pkg.sv
// Shared constants, step/state types and command-byte lookup for the
// configuration-load sequencer.
package spi_prog_pkg;

    typedef enum logic [2:0] {
        STEP_EN    = 3'd0,
        STEP_EN_RD = 3'd1,
        STEP_PRG   = 3'd2,
        STEP_FRAME = 3'd3,
        STEP_DIS   = 3'd4,
        STEP_REL   = 3'd5
    } step_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_PGO, SQ_PWAIT, SQ_SEND, SQ_SENDW, SQ_SETTLE
    } seq_t;

    localparam logic [3:0] ERR_NONE    = 4'd0;
    localparam logic [3:0] ERR_PARTIAL = 4'd1;
    localparam logic [3:0] ERR_LENGTH  = 4'd2;
    localparam logic [3:0] ERR_ISC     = 4'd3;

    localparam logic [7:0] OP_STATUS  = 8'h00;
    localparam logic [7:0] OP_FETCH   = 8'h01;
    localparam logic [7:0] OP_ISC_ON  = 8'h0B;
    localparam logic [7:0] OP_ISC_OFF = 8'h0C;
    localparam logic [7:0] OP_LEAVE   = 8'h23;
    localparam logic [7:0] OP_PRELUDE = 8'hAE;
    localparam logic [7:0] OP_MODE    = 8'h01;
    localparam logic [7:0] OP_FRAME   = 8'hEE;

    localparam int FRAME_BYTES = 16;
    localparam int ST_BUSY  = 0;
    localparam int ST_READY = 1;
    localparam int ST_VIOL  = 2;
    localparam int ST_FAULT = 3;

    // Number of bytes in the chip-select burst of a step.
    function automatic logic [4:0] cmd_len(step_t s);
        case (s)
            STEP_EN_RD, STEP_PRG: cmd_len = 5'd2;
            STEP_FRAME:           cmd_len = 5'(FRAME_BYTES + 1);
            default:              cmd_len = 5'd1;
        endcase
    endfunction

    // Fixed byte at a given position of a step's burst (frame data excluded).
    function automatic logic [7:0] cmd_byte(step_t s, logic [4:0] idx);
        case (s)
            STEP_EN:    cmd_byte = OP_ISC_ON;
            STEP_EN_RD: cmd_byte = (idx == 5'd0) ? OP_FETCH : 8'h00;
            STEP_PRG:   cmd_byte = (idx == 5'd0) ? OP_PRELUDE : OP_MODE;
            STEP_FRAME: cmd_byte = OP_FRAME;
            STEP_DIS:   cmd_byte = OP_ISC_OFF;
            default:    cmd_byte = OP_LEAVE;
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
// One-byte SPI master, mode 0, MSB first.
// Assumes: start is only honoured while idle; with hold_cs set the chip
// select stays low after the byte so the next byte joins the same burst.
module spi_byte_engine #(
    parameter int DIV = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       hold_cs,
    input  logic [7:0] tx_byte,
    output logic [7:0] rx_byte,
    output logic       done,
    output logic       sclk,
    output logic       cs_n,
    output logic       mosi,
    input  logic       miso
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_cnt;
    logic [3:0]    edge_cnt;
    logic          active;
    logic          hold_q;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;

    // Half-period timing, sampling on rising and shifting on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt  <= '0;
            edge_cnt <= '0;
            active   <= 1'b0;
            hold_q   <= 1'b0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            sclk     <= 1'b0;
            cs_n     <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active) begin
                if (start) begin
                    active   <= 1'b1;
                    cs_n     <= 1'b0;
                    tx_sh    <= tx_byte;
                    hold_q   <= hold_cs;
                    edge_cnt <= '0;
                    div_cnt  <= '0;
                end
            end else if (div_cnt == DW'(DIV - 1)) begin
                div_cnt  <= '0;
                edge_cnt <= edge_cnt + 4'd1;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    sclk  <= 1'b0;
                    tx_sh <= {tx_sh[6:0], 1'b0};
                    if (edge_cnt == 4'd15) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                        if (!hold_q) cs_n <= 1'b1;
                    end
                end
            end else begin
                div_cnt <= div_cnt + DW'(1);
            end
        end
    end

    assert_sclk_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    assert_cs_held_in_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> !cs_n);
endmodule

// File: rtl/status_poller.sv
// Reads the target status byte (two bursts, second one judged) until busy is
// clear and all mask bits are set, a fault bit shows, or the attempt limit
// is used up. Assumes it owns the byte engine from go until ok/fail.
module status_poller
    import spi_prog_pkg::*;
#(
    parameter int MAX_POLLS = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] mask,
    output logic       spi_start,
    input  logic       spi_done,
    input  logic [7:0] spi_rx,
    output logic       ok,
    output logic       fail
);
    localparam int AW = $clog2(MAX_POLLS + 1);

    typedef enum logic [2:0] {P_IDLE, P_RD1, P_RD1W, P_RD2, P_RD2W} pst_t;

    pst_t          st;
    logic [AW-1:0] attempts;
    logic [7:0]    need;
    logic          faulted;
    logic          satisfied;

    assign spi_start = (st == P_RD1) || (st == P_RD2);
    assign faulted   = spi_rx[ST_VIOL] | spi_rx[ST_FAULT];
    assign satisfied = ((spi_rx & (need | 8'h01)) == need);

    // Poll loop: two status bursts per attempt, verdict on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= P_IDLE;
            attempts <= '0;
            need     <= '0;
            ok       <= 1'b0;
            fail     <= 1'b0;
        end else begin
            ok   <= 1'b0;
            fail <= 1'b0;
            case (st)
                P_IDLE: if (go) begin
                    st       <= P_RD1;
                    attempts <= '0;
                    need     <= mask;
                end
                P_RD1:  st <= P_RD1W;
                P_RD1W: if (spi_done) st <= P_RD2;
                P_RD2:  st <= P_RD2W;
                P_RD2W: if (spi_done) begin
                    if (faulted) begin
                        fail <= 1'b1;
                        st   <= P_IDLE;
                    end else if (satisfied) begin
                        ok <= 1'b1;
                        st <= P_IDLE;
                    end else if (attempts == AW'(MAX_POLLS - 1)) begin
                        fail <= 1'b1;
                        st   <= P_IDLE;
                    end else begin
                        attempts <= attempts + AW'(1);
                        st       <= P_RD1;
                    end
                end
                default: st <= P_IDLE;
            endcase
        end
    end

    assert_ok_needs_idle_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ok |-> !spi_rx[ST_BUSY]);
    assert_verdict_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ok || fail) |-> (st == P_IDLE && !(ok && fail)));
endmodule

// File: rtl/settle_timer.sv
// One-shot cycle counter for the settling gap between disable and release.
// Assumes CLK_HZ is the clock frequency; the wait is CLK_HZ/1000 cycles.
module settle_timer #(
    parameter int CLK_HZ = 200_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic expired
);
    localparam int WAIT_CYC = (CLK_HZ / 1000 > 1) ? CLK_HZ / 1000 : 2;
    localparam int TW = $clog2(WAIT_CYC + 1);

    logic [TW-1:0] cnt;
    logic          run;

    // Count from kick, flag once the full wait has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            run     <= 1'b0;
            expired <= 1'b0;
        end else begin
            expired <= 1'b0;
            if (kick) begin
                run <= 1'b1;
                cnt <= '0;
            end else if (run) begin
                if (cnt == TW'(WAIT_CYC - 1)) begin
                    run     <= 1'b0;
                    expired <= 1'b1;
                end else begin
                    cnt <= cnt + TW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/spi_prog_seq.sv
// Configuration-load sequencer: enable, read-back check, mode entry, frames,
// disable, settle, release. Assumes the image stream delivers each frame's
// 16 bytes promptly, since chip select stays low while a frame waits on data.
module spi_prog_seq
    import spi_prog_pkg::*;
#(
    parameter int CLK_HZ    = 200_000_000,
    parameter int SPI_DIV   = 4,
    parameter int MAX_POLLS = 4096,
    parameter int COUNT_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               partial,
    input  logic [COUNT_W-1:0] byte_count,
    input  logic [7:0]         in_data,
    input  logic               in_valid,
    output logic               in_ready,
    output logic               busy,
    output logic               done,
    output logic [3:0]         err_code,
    output logic               prog_mode,
    output logic               spi_sclk,
    output logic               spi_cs_n,
    output logic               spi_mosi,
    input  logic               spi_miso
);
    localparam int FW = COUNT_W - 4;

    seq_t          st;
    step_t         step;
    logic [4:0]    idx;
    logic [FW-1:0] frames_left;

    logic       eng_start, eng_hold, eng_done;
    logic [7:0] eng_tx, eng_rx;
    logic       p_start, p_ok, p_fail, p_go;
    logic [7:0] p_mask;
    logic       is_data, last_byte, send_go, tmr_kick, tmr_exp;

    assign busy      = (st != SQ_IDLE);
    assign is_data   = (step == STEP_FRAME) && (idx != 5'd0);
    assign last_byte = (idx == cmd_len(step) - 5'd1);
    assign send_go   = (st == SQ_SEND) && (!is_data || in_valid);
    assign in_ready  = (st == SQ_SEND) && is_data;
    assign p_go      = (st == SQ_PGO);
    assign p_mask    = (step == STEP_EN_RD) ? 8'(1 << ST_READY) : 8'h00;
    assign tmr_kick  = (st == SQ_SENDW) && eng_done && last_byte && (step == STEP_DIS);

    // Byte engine is shared: the poller drives it outside the send states.
    assign eng_start = send_go | p_start;
    assign eng_hold  = (st == SQ_SEND) && !last_byte;
    assign eng_tx    = (st != SQ_SEND) ? OP_STATUS : (is_data ? in_data : cmd_byte(step, idx));

    spi_byte_engine #(.DIV(SPI_DIV)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .hold_cs(eng_hold),
        .tx_byte(eng_tx), .rx_byte(eng_rx), .done(eng_done),
        .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
    );

    status_poller #(.MAX_POLLS(MAX_POLLS)) u_poll (
        .clk(clk), .rst_n(rst_n), .go(p_go), .mask(p_mask),
        .spi_start(p_start), .spi_done(eng_done), .spi_rx(eng_rx),
        .ok(p_ok), .fail(p_fail)
    );

    settle_timer #(.CLK_HZ(CLK_HZ)) u_tmr (
        .clk(clk), .rst_n(rst_n), .kick(tmr_kick), .expired(tmr_exp)
    );

    // Step sequencing, request screening and result reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= SQ_IDLE;
            step        <= STEP_EN;
            idx         <= '0;
            frames_left <= '0;
            done        <= 1'b0;
            err_code    <= ERR_NONE;
            prog_mode   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                SQ_IDLE: if (start) begin
                    if (partial) begin
                        err_code <= ERR_PARTIAL;
                        done     <= 1'b1;
                    end else if (byte_count[3:0] != 4'd0 || byte_count == '0) begin
                        err_code <= ERR_LENGTH;
                        done     <= 1'b1;
                    end else begin
                        err_code    <= ERR_NONE;
                        step        <= STEP_EN;
                        frames_left <= byte_count[COUNT_W-1:4];
                        st          <= SQ_PGO;
                    end
                end
                SQ_PGO: st <= SQ_PWAIT;
                SQ_PWAIT: begin
                    if (p_ok) begin
                        idx <= '0;
                        st  <= SQ_SEND;
                    end else if (p_fail) begin
                        err_code <= {1'b1, step};
                        done     <= 1'b1;
                        st       <= SQ_IDLE;
                    end
                end
                SQ_SEND: if (send_go) st <= SQ_SENDW;
                SQ_SENDW: if (eng_done) begin
                    if (!last_byte) begin
                        idx <= idx + 5'd1;
                        st  <= SQ_SEND;
                    end else begin
                        case (step)
                            STEP_EN: begin
                                step <= STEP_EN_RD;
                                st   <= SQ_PGO;
                            end
                            STEP_EN_RD: begin
                                if (eng_rx != 8'h00) begin
                                    err_code <= ERR_ISC;
                                    done     <= 1'b1;
                                    st       <= SQ_IDLE;
                                end else begin
                                    step <= STEP_PRG;
                                    st   <= SQ_PGO;
                                end
                            end
                            STEP_PRG: begin
                                prog_mode <= 1'b1;
                                step      <= STEP_FRAME;
                                st        <= SQ_PGO;
                            end
                            STEP_FRAME: begin
                                frames_left <= frames_left - FW'(1);
                                if (frames_left == FW'(1)) step <= STEP_DIS;
                                st <= SQ_PGO;
                            end
                            STEP_DIS: begin
                                step <= STEP_REL;
                                st   <= SQ_SETTLE;
                            end
                            default: begin
                                prog_mode <= 1'b0;
                                done      <= 1'b1;
                                st        <= SQ_IDLE;
                            end
                        endcase
                    end
                end
                SQ_SETTLE: if (tmr_exp) st <= SQ_PGO;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assert_partial_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE && start && partial) |=> (done && err_code == ERR_PARTIAL && !busy));
    assert_length_refused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SQ_IDLE && start && !partial && (byte_count[3:0] != 4'd0 || byte_count == '0))
        |=> (done && err_code == ERR_LENGTH));
    assert_ready_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (step == STEP_FRAME && !spi_cs_n));
    assert_mode_after_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_mode) |-> ($past(step) == STEP_PRG));
    assert_mode_clear_on_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_mode) |-> (done && err_code == ERR_NONE));
    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_spi_prog_seq.sv
module sim_spi_prog_seq;
    localparam int CW       = 16;
    localparam int HZ       = 2_000_000;
    localparam int WAIT_CYC = HZ / 1000;
    localparam int NPOLL    = 8;
    localparam int LIMIT    = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, partial = 1'b0;
    logic [CW-1:0] byte_count = '0;
    logic [7:0] in_data;
    logic in_valid, in_ready, busy, done, prog_mode;
    logic [3:0] err_code;
    logic sclk, cs_n, mosi, miso;

    always #2.5 clk = ~clk;

    spi_prog_seq #(.CLK_HZ(HZ), .SPI_DIV(2), .MAX_POLLS(NPOLL), .COUNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .partial(partial), .byte_count(byte_count),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready), .busy(busy),
        .done(done), .err_code(err_code), .prog_mode(prog_mode),
        .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso)
    );

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Image stream source
    int feed_len = 0, feed_idx = 0, feed_base = 0;
    bit feed_clr = 1'b0;
    assign in_valid = (feed_idx < feed_len);
    assign in_data  = 8'(feed_base + feed_idx);
    always @(posedge clk) begin
        if (feed_clr) feed_idx <= 0;
        else if (in_valid && in_ready) feed_idx <= feed_idx + 1;
    end

    // Behavioural target
    logic [7:0] m_in = 8'h00, m_out = 8'h00, m_op = 8'h00;
    int m_bits, m_byte, m_busy_cnt, m_busy_after, m_ncmd, m_nstat, m_nframe;
    int m_since, m_viol, m_ndat, m_end0c, m_gap;
    bit m_active = 0, m_load = 0, m_ready = 0, m_fault = 0, m_last_busy = 0, m_gap_pend = 0;
    logic [7:0] m_isc = 8'h00, m_fop = 8'hFF, m_sent = 8'h00;
    logic [7:0] m_ops [0:31];
    int m_lens [0:31];
    logic [7:0] m_dat [0:63];

    assign miso = m_out[7];

    function automatic logic [7:0] stat_now();
        return {4'b0, m_fault, 1'b0, m_ready, (m_busy_cnt > 0)};
    endfunction

    task automatic m_clear();
        m_ncmd = 0; m_nstat = 0; m_nframe = 0; m_since = 0; m_viol = 0; m_ndat = 0;
        m_ready = 0; m_fault = 0; m_busy_cnt = 0; m_gap = -1; m_gap_pend = 0; m_last_busy = 0;
    endtask

    always @(negedge cs_n) begin
        m_active = 1; m_bits = 0; m_byte = 0; m_load = 0;
        m_sent = stat_now(); m_out = m_sent;
        if (m_gap_pend) begin m_gap = cyc - m_end0c; m_gap_pend = 0; end
    end

    always @(posedge sclk) if (m_active) begin
        m_in = {m_in[6:0], mosi};
        m_bits++;
        if (m_bits == 8) begin
            m_bits = 0;
            if (m_byte == 0) begin
                m_op = m_in;
                if (m_in != 8'h00) begin
                    // R1/R2: status pairs with busy clear must precede a command
                    if (m_since == 0 || (m_since % 2) != 0 || m_last_busy) m_viol++;
                end
            end else if (m_op == 8'hEE && m_ndat < 64) begin
                m_dat[m_ndat] = m_in; m_ndat++;
            end
            m_load = 1;
            m_byte++;
        end
    end

    always @(negedge sclk) if (m_active) begin
        if (m_load) begin
            m_out = (m_op == 8'h01 && m_byte == 1) ? m_isc : 8'h00;
            m_load = 0;
        end else m_out = {m_out[6:0], 1'b0};
    end

    always @(posedge cs_n) if (m_active) begin
        m_active = 0;
        if (m_op == 8'h00 && m_byte == 1) begin
            m_nstat++; m_since++;
            m_last_busy = m_sent[0];
            if (m_busy_cnt > 0) m_busy_cnt--;
        end else begin
            if (m_ncmd < 32) begin m_ops[m_ncmd] = m_op; m_lens[m_ncmd] = m_byte; end
            m_ncmd++; m_since = 0;
            m_busy_cnt = m_busy_after;
            if (m_op == 8'hEE) m_nframe++;
            if (m_op == 8'h0B) m_ready = 1;
            if (m_op == m_fop) m_fault = 1;
            if (m_op == 8'h0C) begin m_end0c = cyc; m_gap_pend = 1; end
        end
    end

    // Vector: partial | count(12) | isc(8) | fault op(8) | stuck | err(4) | frames(4) | prog
    localparam int NV = 13;
    localparam logic [38:0] VEC [NV] = '{
        {1'b0, 12'd32, 8'h00, 8'hFF, 1'b0, 4'd0,  4'd2, 1'b0},
        {1'b0, 12'd16, 8'h00, 8'hFF, 1'b0, 4'd0,  4'd1, 1'b0},
        {1'b0, 12'd48, 8'h00, 8'hFF, 1'b0, 4'd0,  4'd3, 1'b0},
        {1'b1, 12'd32, 8'h00, 8'hFF, 1'b0, 4'd1,  4'd0, 1'b0},
        {1'b0, 12'd20, 8'h00, 8'hFF, 1'b0, 4'd2,  4'd0, 1'b0},
        {1'b0, 12'd0,  8'h00, 8'hFF, 1'b0, 4'd2,  4'd0, 1'b0},
        {1'b0, 12'd16, 8'h05, 8'hFF, 1'b0, 4'd3,  4'd0, 1'b0},
        {1'b0, 12'd16, 8'h00, 8'hFF, 1'b1, 4'd8,  4'd0, 1'b0},
        {1'b0, 12'd32, 8'h00, 8'hAE, 1'b0, 4'd11, 4'd0, 1'b1},
        {1'b0, 12'd16, 8'h00, 8'hFF, 1'b0, 4'd0,  4'd1, 1'b0},
        {1'b0, 12'd16, 8'h00, 8'h0C, 1'b0, 4'd13, 4'd1, 1'b1},
        {1'b0, 12'd32, 8'h00, 8'hEE, 1'b0, 4'd11, 4'd1, 1'b1},
        {1'b0, 12'd16, 8'h00, 8'hFF, 1'b0, 4'd0,  4'd1, 1'b0}
    };

    task automatic prep(input int cnt, input int base, input logic [7:0] isc,
                        input logic [7:0] fop, input bit stuck);
        m_clear();
        m_isc = isc; m_fop = fop;
        m_busy_after = stuck ? 1000000 : 2;
        m_busy_cnt   = stuck ? 1000000 : 0;
        @(negedge clk);
        feed_clr = 1; feed_len = cnt; feed_base = base;
        @(negedge clk);
        feed_clr = 0;
    endtask

    task automatic wait_done(output int waited);
        waited = -1;
        for (int c = 0; c < LIMIT; c++) begin
            if (done) begin waited = c; break; end
            @(negedge clk);
        end
    endtask

    initial begin
        int w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10/R11: idle pins and outputs after reset
        chk(cs_n === 1'b1 && sclk === 1'b0, "R10", {cs_n, sclk}, 2);
        chk(busy === 1'b0 && done === 1'b0 && prog_mode === 1'b0 && err_code === 4'd0 && in_ready === 1'b0,
            "R11", {busy, done, prog_mode, in_ready}, 0);

        for (int k = 0; k < NV; k++) begin
            logic [38:0] v;
            int cnt, ef, base;
            v = VEC[k];
            cnt = int'(v[37:26]); ef = int'(v[4:1]); base = k * 17 + 3;
            prep(cnt, base, v[25:18], v[17:10], v[9]);
            start = 1'b1; partial = v[38]; byte_count = CW'(cnt);
            @(negedge clk);
            start = 1'b0; partial = 1'b0;
            wait_done(w);
            chk(w >= 0, "R11", w, 1);
            chk(err_code == v[8:5], "R9", err_code, v[8:5]);
            chk(m_nframe == ef, "R5", m_nframe, ef);
            chk(prog_mode == v[0], "R4", prog_mode, v[0]);
            chk(m_viol == 0, "R1", m_viol, 0);
            if (v[8:5] == 4'd1 || v[8:5] == 4'd2) begin
                chk(w == 0, "R6", w, 0);
                chk(m_ncmd + m_nstat == 0, "R7", m_ncmd + m_nstat, 0);
            end
            if (v[8:5] == 4'd3) chk(m_ncmd == 2 && m_ops[1] == 8'h01 && m_lens[1] == 2, "R3", m_ncmd, 2);
            if (v[8:5] == 4'd0) begin
                bit seq_ok, dat_ok;
                seq_ok = (m_ncmd == 5 + ef) && m_ops[0] == 8'h0B && m_lens[0] == 1 &&
                         m_ops[1] == 8'h01 && m_lens[1] == 2 && m_ops[2] == 8'hAE && m_lens[2] == 2;
                for (int f = 0; f < ef; f++)
                    if (m_ops[3 + f] != 8'hEE || m_lens[3 + f] != 17) seq_ok = 0;
                if (m_ops[3 + ef] != 8'h0C || m_ops[4 + ef] != 8'h23) seq_ok = 0;
                chk(seq_ok, "R4", m_ncmd, 5 + ef);
                dat_ok = (m_ndat == 16 * ef);
                for (int i = 0; i < 16 * ef; i++) if (m_dat[i] != 8'(base + i)) dat_ok = 0;
                chk(dat_ok, "R5", m_ndat, 16 * ef);
                chk(m_gap >= WAIT_CYC && m_gap <= 2 * WAIT_CYC, "R8", m_gap, WAIT_CYC);
                chk(m_nstat >= 2 * (5 + ef) && (m_nstat % 2) == 0, "R2", m_nstat, 2 * (5 + ef));
            end
            @(negedge clk);
            chk(done === 1'b0 && busy === 1'b0, "R11", {done, busy}, 0);
        end

        // R11: a second start during a run is ignored
        prep(16, 200, 8'h00, 8'hFF, 0);
        start = 1'b1; byte_count = CW'(16);
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        chk(busy === 1'b1, "R11", busy, 1);
        start = 1'b1; partial = 1'b1; byte_count = CW'(5);
        @(negedge clk);
        start = 1'b0; partial = 1'b0;
        wait_done(w);
        chk(err_code == 4'd0 && m_nframe == 1, "R11", err_code, 0);

        // R10/R4: reset in the middle of a run returns everything to idle
        prep(32, 90, 8'h00, 8'hFF, 0);
        start = 1'b1; byte_count = CW'(32);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < LIMIT && !prog_mode; c++) @(negedge clk);
        chk(prog_mode === 1'b1, "R4", prog_mode, 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && prog_mode === 1'b0,
            "R10", {cs_n, sclk, busy, prog_mode}, 8);
        rst_n = 1'b1;
        @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule